// File: doc/BRIEF.md
# Floating-Point Operand Register Decoder

This block looks at one 32-bit floating-point instruction word and, in the same cycle, tells the surrounding logic what that word means for the register file. It recognises the two floating-point opcode groups and extracts the 9-bit operation selector. It names the precision of the destination and of both sources, and turns each 5-bit register field into a 6-bit physical index into a 64-entry single-word register file. It also reports which half of the file each operand lands in.

The block also decides whether the instruction may proceed. A quad operand whose field names a misaligned register is rejected, and the block then proposes a trap-type value of 6. Each known operation expects a particular trap-type value in the status word: 3 for quad work, 2 for single and double arithmetic. A disagreement rejects the word and leaves the trap type untouched, unless the illegal-instruction entry flag bypasses the comparison. Sources in a half that has never been written are flagged so they can be fed as zero. All outputs are purely combinational.

Top module: `fp_operand_decode`

## Requirements
- R1: `op_group` is 1 when `fp_word & 0xC1F80000 == 0x81A00000`, 2 when the masked value equals 0x81A80000, and 0 otherwise. A word in neither group gives `known_op` = 0.
- R2: `op_sel` equals `fp_word[13:5]`. The destination field is bits 29:25, source 1 is bits 18:14 and source 2 is bits 4:0.
- R3: Precision codes are 0 none, 1 single, 2 double, 3 quad. In group 1, 0x041 uses single for all three operands, 0x042 double for all three, and 0x043 quad for all three. 0x06E has a quad destination and double sources. 0x0D3 has a single destination, a quad source 2 and no source 1. 0x029 has single source 2 and destination only. In group 2, 0x053 has quad sources and no register destination.
- R4: A single operand's index is the field zero-extended. A double or quad operand's index is {field[0], field[4:1], 0}. An absent operand's index is 0.
- R5: Each `*_upper` output is 1 exactly when the operand is present and its index is 32 or more.
- R6: A source's `*_zero` output is 1 when the source is present and the half it touches is not live. `half_live[0]` covers the lower half and `half_live[1]` covers the upper half.
- R7: For a known operation, a quad operand whose field has bit 1 set raises `quad_misalign`. If the trap check passes, `accept` is then 0 and `trap_field_next` is 6.
- R8: Quad-group operations expect trap type 3, and single and double arithmetic expect 2. Single and double square root, 0x029 and 0x02A, accept any trap type. On a mismatch, `trap_mismatch` is 1, `accept` is 0 and `trap_field_next` equals `trap_field`. A mismatch takes precedence over misalignment.
- R9: With `bypass_trap_chk` = 1, the trap-type comparison has no effect: `trap_mismatch` is 0.
- R10: An operation code the decoder does not handle gives `known_op` = 0, all precisions 0, `accept` = 0 and `trap_field_next` = `trap_field`.
- R11: An accepted word gives `trap_field_next` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fp_word | input | 32 | Instruction word under decode |
| trap_field | input | 3 | Current trap-type field from the status word |
| bypass_trap_chk | input | 1 | Entered through the illegal-instruction path; skip the trap-type compare |
| half_live | input | 2 | Register-file halves already written: [0] lower, [1] upper |
| op_group | output | 2 | 0 none, 1 first opcode group, 2 second opcode group |
| op_sel | output | 9 | Operation selector field |
| known_op | output | 1 | Operation is decoded by this block |
| rd_prec | output | 2 | Destination precision |
| rs1_prec | output | 2 | Source 1 precision |
| rs2_prec | output | 2 | Source 2 precision |
| rd_idx | output | 6 | Destination physical index |
| rs1_idx | output | 6 | Source 1 physical index |
| rs2_idx | output | 6 | Source 2 physical index |
| rd_upper | output | 1 | Destination lies in the upper half |
| rs1_upper | output | 1 | Source 1 lies in the upper half |
| rs2_upper | output | 1 | Source 2 lies in the upper half |
| rs1_zero | output | 1 | Source 1 must read as zero |
| rs2_zero | output | 1 | Source 2 must read as zero |
| quad_misalign | output | 1 | A quad operand names a misaligned register |
| trap_mismatch | output | 1 | Expected trap type differs from `trap_field` |
| accept | output | 1 | Instruction may proceed |
| trap_field_next | output | 3 | Trap-type value to write back |

## Verification
The block holds no state, so any internal fault shows at the ports in the same cycle as the offending word. A wrong entry in the precision table appears at once as a wrong precision code. It also moves an index by doubling or bit rotation, sets the wrong upper flag, or flips `accept` through a false misalignment or trap mismatch. The directed cases use distinct field values in every slot so that a swapped field or a mis-ordered remap bit changes a checked index. They also cover every ordering of mismatch against misalignment.

// File: rtl/fp_operand_decode.sv
module fp_operand_decode (
  input  logic [31:0] fp_word,
  input  logic [2:0]  trap_field,
  input  logic        bypass_trap_chk,
  input  logic [1:0]  half_live,
  output logic [1:0]  op_group,
  output logic [8:0]  op_sel,
  output logic        known_op,
  output logic [1:0]  rd_prec,
  output logic [1:0]  rs1_prec,
  output logic [1:0]  rs2_prec,
  output logic [5:0]  rd_idx,
  output logic [5:0]  rs1_idx,
  output logic [5:0]  rs2_idx,
  output logic        rd_upper,
  output logic        rs1_upper,
  output logic        rs2_upper,
  output logic        rs1_zero,
  output logic        rs2_zero,
  output logic        quad_misalign,
  output logic        trap_mismatch,
  output logic        accept,
  output logic [2:0]  trap_field_next
);

  localparam logic [31:0] GRP_MASK  = 32'hC1F8_0000;
  localparam logic [31:0] GRP_A_VAL = 32'h81A0_0000;
  localparam logic [31:0] GRP_B_VAL = 32'h81A8_0000;
  localparam logic [2:0]  TT_QUAD   = 3'd3;
  localparam logic [2:0]  TT_SUBN   = 3'd2;
  localparam logic [2:0]  TT_BADREG = 3'd6;
  localparam logic [1:0]  P_NONE = 2'd0, P_SGL = 2'd1, P_DBL = 2'd2, P_QD = 2'd3;

  logic       grp_a, grp_b, any_tt;
  logic [2:0] want_tt;

  function automatic logic [5:0] map_reg(input logic [4:0] f, input logic [1:0] p);
    case (p)
      P_NONE:  map_reg = 6'd0;
      P_SGL:   map_reg = {1'b0, f};
      default: map_reg = {f[0], f[4:1], 1'b0};
    endcase
  endfunction

  function automatic logic bad_quad(input logic [4:0] f, input logic [1:0] p);
    bad_quad = (p == P_QD) && f[1];
  endfunction

  assign grp_a    = (fp_word & GRP_MASK) == GRP_A_VAL;
  assign grp_b    = (fp_word & GRP_MASK) == GRP_B_VAL;
  assign op_group = grp_a ? 2'd1 : (grp_b ? 2'd2 : 2'd0);
  assign op_sel   = fp_word[13:5];

  always_comb begin
    known_op = 1'b1;
    want_tt  = TT_QUAD;
    any_tt   = 1'b0;
    rd_prec  = P_NONE;
    rs1_prec = P_NONE;
    rs2_prec = P_NONE;
    if (grp_a) begin
      case (op_sel)
        9'h003, 9'h007, 9'h00B: begin rd_prec = P_QD; rs2_prec = P_QD; end
        9'h02B: begin rd_prec = P_QD; rs2_prec = P_QD; end
        9'h043, 9'h047, 9'h04B, 9'h04F: begin
          rd_prec = P_QD; rs1_prec = P_QD; rs2_prec = P_QD;
        end
        9'h06E: begin rd_prec = P_QD; rs1_prec = P_DBL; rs2_prec = P_DBL; end
        9'h083: begin rd_prec = P_DBL; rs2_prec = P_QD; end
        9'h08C: begin rd_prec = P_QD; rs2_prec = P_DBL; end
        9'h0C7: begin rd_prec = P_SGL; rs2_prec = P_QD; end
        9'h0CB: begin rd_prec = P_DBL; rs2_prec = P_QD; end
        9'h0CC, 9'h0CD: begin rd_prec = P_QD; rs2_prec = P_SGL; end
        9'h0CE: begin rd_prec = P_QD; rs2_prec = P_DBL; end
        9'h0D3: begin rd_prec = P_SGL; rs2_prec = P_QD; end
        9'h029: begin any_tt = 1'b1; rd_prec = P_SGL; rs2_prec = P_SGL; end
        9'h02A: begin any_tt = 1'b1; rd_prec = P_DBL; rs2_prec = P_DBL; end
        9'h042, 9'h046, 9'h04A, 9'h04E: begin
          want_tt = TT_SUBN; rd_prec = P_DBL; rs1_prec = P_DBL; rs2_prec = P_DBL;
        end
        9'h041, 9'h045, 9'h049, 9'h04D: begin
          want_tt = TT_SUBN; rd_prec = P_SGL; rs1_prec = P_SGL; rs2_prec = P_SGL;
        end
        9'h069: begin
          want_tt = TT_SUBN; rd_prec = P_DBL; rs1_prec = P_SGL; rs2_prec = P_SGL;
        end
        9'h081, 9'h0C9, 9'h0C8: begin want_tt = TT_SUBN; rd_prec = P_DBL; rs2_prec = P_SGL; end
        9'h082, 9'h088: begin want_tt = TT_SUBN; rd_prec = P_DBL; rs2_prec = P_DBL; end
        9'h0C6, 9'h0D2, 9'h084: begin want_tt = TT_SUBN; rd_prec = P_SGL; rs2_prec = P_DBL; end
        9'h0D1: begin want_tt = TT_SUBN; rd_prec = P_SGL; rs2_prec = P_SGL; end
        default: known_op = 1'b0;
      endcase
    end else if (grp_b) begin
      case (op_sel)
        9'h053, 9'h057: begin rs1_prec = P_QD; rs2_prec = P_QD; end
        default: known_op = 1'b0;
      endcase
    end else begin
      known_op = 1'b0;
    end
  end

  assign rd_idx  = map_reg(fp_word[29:25], rd_prec);
  assign rs1_idx = map_reg(fp_word[18:14], rs1_prec);
  assign rs2_idx = map_reg(fp_word[4:0],   rs2_prec);

  assign rd_upper  = rd_idx[5];
  assign rs1_upper = rs1_idx[5];
  assign rs2_upper = rs2_idx[5];

  assign rs1_zero = (rs1_prec != P_NONE) && !half_live[rs1_idx[5]];
  assign rs2_zero = (rs2_prec != P_NONE) && !half_live[rs2_idx[5]];

  assign quad_misalign = known_op && (bad_quad(fp_word[29:25], rd_prec) ||
                                      bad_quad(fp_word[18:14], rs1_prec) ||
                                      bad_quad(fp_word[4:0],   rs2_prec));
  assign trap_mismatch = known_op && !bypass_trap_chk && !any_tt && (want_tt != trap_field);
  assign accept        = known_op && !trap_mismatch && !quad_misalign;
  assign trap_field_next = accept ? 3'd0 :
                           (known_op && !trap_mismatch) ? TT_BADREG : trap_field;

  always_comb begin
    if (!$isunknown({fp_word, trap_field, bypass_trap_chk, half_live})) begin
      // R7
      quad_aligned_chk: assert (!accept || ((rd_prec != P_QD || rd_idx[1:0] == 2'b00) &&
                                            (rs1_prec != P_QD || rs1_idx[1:0] == 2'b00) &&
                                            (rs2_prec != P_QD || rs2_idx[1:0] == 2'b00)))
        else $error("accepted quad operand with misaligned index");
      // R4
      wide_even_chk: assert ((rd_prec < P_DBL || !rd_idx[0]) &&
                             (rs1_prec < P_DBL || !rs1_idx[0]) &&
                             (rs2_prec < P_DBL || !rs2_idx[0]))
        else $error("odd index for double or quad operand");
      // R5
      single_low_chk: assert ((rd_prec != P_SGL || !rd_upper) &&
                              (rs1_prec != P_SGL || !rs1_upper) &&
                              (rs2_prec != P_SGL || !rs2_upper))
        else $error("single operand mapped to upper half");
      // R6
      zero_half_chk: assert ((!rs1_zero || !half_live[rs1_upper]) &&
                             (!rs2_zero || !half_live[rs2_upper]))
        else $error("zero flag set for a live half");
      // R8
      verdict_chk: assert ($onehot0({accept, trap_mismatch}))
        else $error("accept raised together with trap mismatch");
      // R10
      unknown_quiet_chk: assert (known_op || (!accept && rd_prec == P_NONE &&
                                 rs1_prec == P_NONE && rs2_prec == P_NONE &&
                                 trap_field_next == trap_field))
        else $error("undecoded operation produced operand activity");
      // R1
      group_known_chk: assert (op_group != 2'd0 || !known_op)
        else $error("known operation outside both groups");
    end
  end

endmodule

// File: tb/tb_fp_operand_decode.sv
module tb_fp_operand_decode;
  logic        clk = 1'b0;
  logic [31:0] fp_word;
  logic [2:0]  trap_field;
  logic        bypass_trap_chk;
  logic [1:0]  half_live;
  logic [1:0]  op_group, rd_prec, rs1_prec, rs2_prec;
  logic [8:0]  op_sel;
  logic        known_op, rd_upper, rs1_upper, rs2_upper, rs1_zero, rs2_zero;
  logic [5:0]  rd_idx, rs1_idx, rs2_idx;
  logic        quad_misalign, trap_mismatch, accept;
  logic [2:0]  trap_field_next;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_operand_decode dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit g2, input logic [4:0] rd, input logic [4:0] rs1,
                                     input logic [8:0] op, input logic [4:0] rs2);
    return {2'b10, rd, g2 ? 6'h35 : 6'h34, rs1, op, rs2};
  endfunction

  task automatic apply(input logic [31:0] w, input logic [2:0] tt, input logic byp, input logic [1:0] hl);
    @(posedge clk);
    fp_word = w; trap_field = tt; bypass_trap_chk = byp; half_live = hl;
    @(negedge clk);
  endtask

  task automatic t_idle;
    apply(32'h0, 3'd4, 1'b0, 2'b11);
    chk("R1", "group", op_group, 0);
    chk("R1", "known", known_op, 0);
    chk("R10", "accept", accept, 0);
    chk("R10", "next", trap_field_next, 4);
  endtask

  task automatic t_single_add;
    apply(mk(0, 5'd3, 5'd5, 9'h041, 5'd31), 3'd2, 1'b0, 2'b11);
    chk("R1", "group", op_group, 1);
    chk("R2", "op_sel", op_sel, 9'h041);
    chk("R3", "precs", {rd_prec, rs1_prec, rs2_prec}, 6'b010101);
    chk("R4", "rd_idx", rd_idx, 3);
    chk("R4", "rs1_idx", rs1_idx, 5);
    chk("R4", "rs2_idx", rs2_idx, 31);
    chk("R11", "accept/next", {accept, trap_field_next}, 4'b1000);
  endtask

  task automatic t_double_add;
    apply(mk(0, 5'd5, 5'd2, 9'h042, 5'd31), 3'd2, 1'b0, 2'b01);
    chk("R3", "precs", {rd_prec, rs1_prec, rs2_prec}, 6'b101010);
    chk("R4", "rd_idx", rd_idx, 36);
    chk("R4", "rs1_idx", rs1_idx, 2);
    chk("R4", "rs2_idx", rs2_idx, 62);
    chk("R5", "uppers", {rd_upper, rs1_upper, rs2_upper}, 3'b101);
    chk("R6", "zeros", {rs1_zero, rs2_zero}, 2'b01);
    chk("R8", "accept", accept, 1);
  endtask

  task automatic t_quad_add;
    apply(mk(0, 5'd4, 5'd8, 9'h043, 5'd1), 3'd3, 1'b0, 2'b10);
    chk("R3", "precs", {rd_prec, rs1_prec, rs2_prec}, 6'b111111);
    chk("R4", "idx", {rd_idx, rs1_idx, rs2_idx}, {6'd4, 6'd8, 6'd32});
    chk("R6", "zeros", {rs1_zero, rs2_zero}, 2'b10);
    chk("R11", "accept/next", {accept, trap_field_next}, 4'b1000);
  endtask

  task automatic t_misalign;
    apply(mk(0, 5'd0, 5'd0, 9'h047, 5'd2), 3'd3, 1'b0, 2'b11);
    chk("R7", "misalign", quad_misalign, 1);
    chk("R7", "accept", accept, 0);
    chk("R7", "next", trap_field_next, 6);
    apply(mk(0, 5'd6, 5'd0, 9'h043, 5'd0), 3'd3, 1'b0, 2'b11);
    chk("R7", "rd misalign next", trap_field_next, 6);
  endtask

  task automatic t_mismatch;
    apply(mk(0, 5'd0, 5'd0, 9'h043, 5'd2), 3'd2, 1'b0, 2'b11);
    chk("R8", "mismatch", trap_mismatch, 1);
    chk("R8", "accept", accept, 0);
    chk("R8", "next unchanged", trap_field_next, 2);
    apply(mk(0, 5'd1, 5'd1, 9'h041, 5'd1), 3'd3, 1'b0, 2'b11);
    chk("R8", "single expects 2", {trap_mismatch, accept}, 2'b10);
  endtask

  task automatic t_bypass;
    apply(mk(0, 5'd0, 5'd0, 9'h043, 5'd0), 3'd5, 1'b1, 2'b11);
    chk("R9", "mismatch", trap_mismatch, 0);
    chk("R9", "accept/next", {accept, trap_field_next}, 4'b1000);
  endtask

  task automatic t_sqrt;
    apply(mk(0, 5'd7, 5'd9, 9'h029, 5'd10), 3'd5, 1'b0, 2'b00);
    chk("R8", "sqrt any tt", accept, 1);
    chk("R3", "precs", {rd_prec, rs1_prec, rs2_prec}, 6'b010001);
    chk("R4", "absent rs1", rs1_idx, 0);
    chk("R6", "zeros", {rs1_zero, rs2_zero}, 2'b01);
  endtask

  task automatic t_mixed;
    apply(mk(0, 5'd8, 5'd3, 9'h06E, 5'd6), 3'd3, 1'b0, 2'b11);
    chk("R3", "dmul precs", {rd_prec, rs1_prec, rs2_prec}, 6'b111010);
    chk("R4", "dmul idx", {rd_idx, rs1_idx, rs2_idx}, {6'd8, 6'd34, 6'd6});
    apply(mk(0, 5'd17, 5'd0, 9'h0D3, 5'd12), 3'd3, 1'b0, 2'b11);
    chk("R3", "qtoi precs", {rd_prec, rs1_prec, rs2_prec}, 6'b010011);
    chk("R5", "qtoi uppers", {rd_upper, rs2_upper}, 2'b00);
    chk("R4", "qtoi idx", {rd_idx, rs2_idx}, {6'd17, 6'd12});
  endtask

  task automatic t_group2;
    apply(mk(1, 5'd1, 5'd4, 9'h053, 5'd9), 3'd3, 1'b0, 2'b11);
    chk("R1", "group", op_group, 2);
    chk("R3", "cmp precs", {rd_prec, rs1_prec, rs2_prec}, 6'b001111);
    chk("R4", "cmp idx", {rd_idx, rs1_idx, rs2_idx}, {6'd0, 6'd4, 6'd40});
    chk("R11", "accept", accept, 1);
    apply(mk(1, 5'd1, 5'd1, 9'h041, 5'd1), 3'd2, 1'b0, 2'b11);
    chk("R10", "g2 unknown", {known_op, accept}, 2'b00);
  endtask

  task automatic t_unknown;
    apply(mk(0, 5'd3, 5'd3, 9'h1FF, 5'd3), 3'd1, 1'b0, 2'b11);
    chk("R10", "known", known_op, 0);
    chk("R10", "precs", {rd_prec, rs1_prec, rs2_prec}, 0);
    chk("R10", "next", trap_field_next, 1);
    chk("R10", "accept", accept, 0);
  endtask

  initial begin
    t_idle;
    t_single_add;
    t_double_add;
    t_quad_add;
    t_misalign;
    t_mismatch;
    t_bypass;
    t_sqrt;
    t_mixed;
    t_group2;
    t_unknown;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule